// File: doc/BRIEF.md
# Time-Shared FIR Filter with Built-In Sawtooth Source

This block is a single-rate FIR filter that takes no audio input. It makes its own test signal: a rising sawtooth that wraps around. On every accepted sample tick it places the current sawtooth value at the head of a delay line. It then forms the sum of coefficient-times-sample products over all taps. Finally it ages the delay line by one position and steps the sawtooth. The one filtered result goes to both the left and the right output channel.

The multiply-accumulate work is spread over a parameterized number of parallel multiplier lanes. A sample therefore costs about taps/lanes cycles, so a longer filter can be traded against fewer lanes as long as the work fits the per-sample cycle budget. That budget is 2559 cycles at a 48 kHz rate. A parameter combination that breaks the budget stops elaboration. A tick that arrives while a sample is still being worked on is dropped and flagged.

Top module: `fir_sawtooth_ts`

## Requirements
- R1: While `rstN` is low, `outLeft`, `outRight`, `outValid` and `overrun` are all zero, and the sawtooth and delay line restart from zero.
- R2: Sample n (counted from 0 after reset over accepted ticks) uses the sawtooth value (n * SAW_STEP) mod 2^23, read as a non-negative signed Q1.23 number. SAW_STEP defaults to 83886 (about 0.01). The sawtooth advances once per accepted tick and never otherwise.
- R3: The accumulated sum for sample n is the sum over taps k of c_k * s(n-k), where s before sample 0 counts as zero. Coefficient c_k is the signed 24-bit field at bits [24k+23:24k] of COEF_ROM. The default is c_k = (((29k + 7) mod 64) - 32) * 2^14.
- R4: The result is rounded by adding 2^22 and shifting right arithmetically by 23. It is then clamped to the range [-2^23, 2^23 - 1].
- R5: `outLeft` and `outRight` always carry the same filtered value.
- R6: `outValid` is a one-cycle pulse. It comes exactly ceil(TAPS/LANES) + 1 clock edges after the edge that accepts the tick. The outputs hold their value between pulses.
- R7: A tick seen while a sample is still in progress raises `overrun` for exactly one cycle, on the next edge. That tick is ignored: it neither starts a sample nor moves the sawtooth.
- R8: Any LANES from 1 to TAPS is valid, including counts that do not divide TAPS evenly. In that case the last lane group handles only the remaining taps.
- R9: Elaboration fails if ceil(TAPS/LANES) + 2 exceeds CYCLE_BUDGET. Ticks spaced exactly ceil(TAPS/LANES) + 2 cycles apart are all accepted without `overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Start of a sample period, one-cycle pulse |
| outLeft | output | 24 | Filtered Q1.23 result, left channel |
| outRight | output | 24 | Filtered Q1.23 result, right channel |
| outValid | output | 1 | Pulses when a new result appears on both channels |
| overrun | output | 1 | Pulses when a tick was dropped because the filter was busy |

## Verification
The embedded properties assume that `sampleTick` is a clean synchronous level, free of unknowns once reset is released. They also assume that the parameters satisfy the elaboration checks, so the busy window stays inside the cycle budget. The stimulus changes the tick only on falling clock edges. It keeps the tick high for a single cycle in normal operation and for two cycles only in the deliberate overrun case. The gaps between ticks are never shorter than the accepted minimum, except in that overrun case.

// File: rtl/fir_ts_pkg.sv
package fir_ts_pkg;

  localparam int SAMPLE_W = 24;
  localparam int MAX_TAPS = 1024;

  // Strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic load;    // head of delay line takes the sawtooth, accumulator clears
    logic accEn;   // add one lane group into the accumulator
    logic finish;  // round, publish, age delay line, step sawtooth
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } phase_e;

  // Default coefficient set, computed so no table is spelled out
  function automatic logic [MAX_TAPS*SAMPLE_W-1:0] defaultCoefs(int taps);
    logic [MAX_TAPS*SAMPLE_W-1:0] rom;
    rom = '0;
    for (int k = 0; k < MAX_TAPS; k++) begin
      if (k < taps) begin
        rom[k*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'((((29 * k + 7) % 64) - 32) * 16384);
      end
    end
    return rom;
  endfunction

endpackage

// File: rtl/fir_ts_ctrl.sv
module fir_ts_ctrl
  import fir_ts_pkg::*;
#(
  parameter int GROUPS       = 12,
  parameter int GRP_W        = 4,
  parameter int CYCLE_BUDGET = 2559
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  output strobe_t          strobe,
  output logic [GRP_W-1:0] grp,
  output logic             overrun
);

  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(GROUPS - 1);
  localparam int CNT_W = $clog2(CYCLE_BUDGET + 1) + 1;

  phase_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      grp     <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= sampleTick && (state != ST_IDLE);
      case (state)
        ST_IDLE: begin
          if (sampleTick) begin
            state <= ST_RUN;
            grp   <= '0;
          end
        end
        ST_RUN: begin
          if (grp == LAST_GRP) state <= ST_FIN;
          else                 grp   <= grp + GRP_W'(1);
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load   = sampleTick && (state == ST_IDLE);
    strobe.accEn  = (state == ST_RUN);
    strobe.finish = (state == ST_FIN);
  end

  // Cycles spent since the accepted tick; watched against the budget
  logic [CNT_W-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 busyCnt <= '0;
    else if (strobe.load)      busyCnt <= CNT_W'(1);
    else if (state != ST_IDLE) busyCnt <= busyCnt + CNT_W'(1);
    else                       busyCnt <= '0;
  end

  // R9: one sample never occupies more cycles than the budget allows
  p_budget_r9: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= CNT_W'(CYCLE_BUDGET));

  // R8: the lane-group counter stays within the computed group count
  p_grp_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    grp <= LAST_GRP);

  // R7: a dropped-tick flag only follows a cycle in which work was pending
  p_overrun_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(state) != ST_IDLE);

  // R7: a tick during work does not restart the group walk
  p_tick_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && state == ST_RUN && grp != LAST_GRP) |=> grp != '0);

endmodule

// File: rtl/fir_ts_datapath.sv
module fir_ts_datapath
  import fir_ts_pkg::*;
#(
  parameter int                              TAPS     = 115,
  parameter int                              LANES    = 10,
  parameter int                              GRP_W    = 4,
  parameter logic [SAMPLE_W-2:0]             SAW_STEP = 23'd83886,
  parameter logic [MAX_TAPS*SAMPLE_W-1:0]    COEF_ROM = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [GRP_W-1:0]    grp,
  output logic [SAMPLE_W-1:0] outSample,
  output logic                outValid
);

  localparam int PROD_W = 2 * SAMPLE_W;
  localparam int PART_W = PROD_W + $clog2(LANES + 1) + 1;
  localparam int ACC_W  = PROD_W + $clog2(TAPS + 1) + 2;
  localparam int SEL_W  = GRP_W + $clog2(LANES + 1) + 1;
  localparam int IDX_W  = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int FRAC   = SAMPLE_W - 1;

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) << FRAC) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [SAMPLE_W-1:0] dl      [TAPS];
  logic signed [SAMPLE_W-1:0] coefTab [TAPS];
  logic signed [PROD_W-1:0]   prod    [LANES];
  logic [SAMPLE_W-2:0]        phase;
  logic signed [ACC_W-1:0]    acc;
  logic signed [PART_W-1:0]   partial;
  logic signed [ACC_W-1:0]    rounded;
  logic [SAMPLE_W-1:0]        satVal;

  // Coefficient ROM unpacked from the parameter vector
  for (genvar k = 0; k < TAPS; k++) begin : g_coef
    assign coefTab[k] = COEF_ROM[k*SAMPLE_W +: SAMPLE_W];
  end

  // One multiplier per lane; lane i handles tap grp*LANES + i
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEL_W-1:0]           sel;
    logic                       inRange;
    logic signed [SAMPLE_W-1:0] coefSel;
    logic signed [SAMPLE_W-1:0] dataSel;

    assign sel     = SEL_W'(grp) * SEL_W'(LANES) + SEL_W'(i);
    assign inRange = sel < SEL_W'(TAPS);
    assign coefSel = inRange ? coefTab[IDX_W'(sel)] : '0;
    assign dataSel = inRange ? dl[IDX_W'(sel)]      : '0;
    assign prod[i] = PROD_W'(coefSel) * PROD_W'(dataSel);
  end

  always_comb begin
    partial = '0;
    for (int i = 0; i < LANES; i++) begin
      partial = partial + {{(PART_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
    end
  end

  // Round half up, then clamp to the Q1.23 range
  always_comb begin
    rounded = (acc + HALF) >>> FRAC;
    if (rounded > MAXV)      satVal = MAXV[SAMPLE_W-1:0];
    else if (rounded < MINV) satVal = MINV[SAMPLE_W-1:0];
    else                     satVal = rounded[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++) dl[k] <= '0;
      phase     <= '0;
      acc       <= '0;
      outSample <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strobe.finish;
      if (strobe.load) begin
        dl[0] <= $signed({1'b0, phase});
        acc   <= '0;
      end
      if (strobe.accEn) begin
        acc <= acc + {{(ACC_W-PART_W){partial[PART_W-1]}}, partial};
      end
      if (strobe.finish) begin
        outSample <= satVal;
        phase     <= phase + SAW_STEP;
        for (int k = 1; k < TAPS; k++) dl[k] <= dl[k-1];
      end
    end
  end

  // R6: results only change when a sample completes
  p_hold_out_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(outSample));

  // R6: the valid flag never lasts two cycles
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R2: the sawtooth moves only at the end of an accepted sample
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(phase));

  // R2: the head of the delay line takes the current sawtooth on acceptance
  p_head_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> dl[0] == $signed({1'b0, $past(phase)}));

  if (TAPS > 1) begin : g_shift_chk
    // R3: ageing moves each entry one position toward the tail
    p_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
      strobe.finish |=> dl[1] == $past(dl[0]));
  end

endmodule

// File: rtl/fir_sawtooth_ts.sv
module fir_sawtooth_ts
  import fir_ts_pkg::*;
#(
  parameter int                           TAPS         = 115,
  parameter int                           LANES        = 10,
  parameter int                           CYCLE_BUDGET = 2559,
  parameter logic [SAMPLE_W-2:0]          SAW_STEP     = 23'd83886,
  parameter logic [MAX_TAPS*SAMPLE_W-1:0] COEF_ROM     = defaultCoefs(TAPS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleTick,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight,
  output logic                outValid,
  output logic                overrun
);

  localparam int GROUPS = (TAPS + LANES - 1) / LANES;
  localparam int GRP_W  = $clog2(GROUPS + 1);

  if (TAPS < 1 || TAPS > MAX_TAPS) begin : g_bad_taps
    $error("fir_sawtooth_ts: TAPS out of range");
  end
  if (LANES < 1 || LANES > TAPS) begin : g_bad_lanes
    $error("fir_sawtooth_ts: LANES must lie in 1..TAPS");
  end
  if (GROUPS + 2 > CYCLE_BUDGET) begin : g_bad_budget
    $error("fir_sawtooth_ts: tap/lane choice exceeds the per-sample cycle budget");
  end

  strobe_t             strobe;
  logic [GRP_W-1:0]    grp;
  logic [SAMPLE_W-1:0] result;

  fir_ts_ctrl #(
    .GROUPS       (GROUPS),
    .GRP_W        (GRP_W),
    .CYCLE_BUDGET (CYCLE_BUDGET)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .strobe     (strobe),
    .grp        (grp),
    .overrun    (overrun)
  );

  fir_ts_datapath #(
    .TAPS     (TAPS),
    .LANES    (LANES),
    .GRP_W    (GRP_W),
    .SAW_STEP (SAW_STEP),
    .COEF_ROM (COEF_ROM)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .grp       (grp),
    .outSample (result),
    .outValid  (outValid)
  );

  assign outLeft  = result;
  assign outRight = result;

endmodule

// File: tb/test_fir_sawtooth_ts.sv
module test_fir_sawtooth_ts;
  import fir_ts_pkg::*;

  localparam int NI = 3;
  localparam int TAPS_OF  [NI] = '{115, 4, 5};
  localparam int LANES_OF [NI] = '{10, 3, 5};
  localparam int GAPS [16] = '{0, 3, 1, 0, 7, 2, 0, 5, 1, 0, 4, 0, 2, 6, 0, 1};

  function automatic logic [MAX_TAPS*SAMPLE_W-1:0] flatRom(logic [SAMPLE_W-1:0] c, int taps);
    logic [MAX_TAPS*SAMPLE_W-1:0] r;
    r = '0;
    for (int k = 0; k < taps; k++) r[k*SAMPLE_W +: SAMPLE_W] = c;
    return r;
  endfunction

  localparam logic [MAX_TAPS*SAMPLE_W-1:0] ROM_POS = flatRom(24'h7FFFFF, 4);
  localparam logic [MAX_TAPS*SAMPLE_W-1:0] ROM_NEG = flatRom(24'h800000, 5);

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                tick     [NI];
  logic [SAMPLE_W-1:0] outL     [NI];
  logic [SAMPLE_W-1:0] outR     [NI];
  logic                valid    [NI];
  logic                ovr      [NI];

  int vecs = 0;
  int errs = 0;
  int satHits = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fir_sawtooth_ts i_fir_sawtooth_ts (
    .clk(clk), .rstN(rstN), .sampleTick(tick[0]),
    .outLeft(outL[0]), .outRight(outR[0]), .outValid(valid[0]), .overrun(ovr[0]));

  fir_sawtooth_ts #(.TAPS(4), .LANES(3), .COEF_ROM(ROM_POS)) i_fir_sawtooth_ts_pos (
    .clk(clk), .rstN(rstN), .sampleTick(tick[1]),
    .outLeft(outL[1]), .outRight(outR[1]), .outValid(valid[1]), .overrun(ovr[1]));

  fir_sawtooth_ts #(.TAPS(5), .LANES(5), .COEF_ROM(ROM_NEG)) i_fir_sawtooth_ts_neg (
    .clk(clk), .rstN(rstN), .sampleTick(tick[2]),
    .outLeft(outL[2]), .outRight(outR[2]), .outValid(valid[2]), .overrun(ovr[2]));

  function automatic longint coefFor(int inst, int k);
    case (inst)
      0:       return longint'((((29 * k + 7) % 64) - 32) * 16384);
      1:       return 64'sd8388607;
      default: return -64'sd8388608;
    endcase
  endfunction

  function automatic longint sawAt(int m);
    return (longint'(m) * 83886) % 8388608;
  endfunction

  function automatic longint expectOut(int inst, int n);
    longint acc = 0;
    longint r;
    for (int k = 0; k < TAPS_OF[inst]; k++) begin
      if (k <= n) acc += coefFor(inst, k) * sawAt(n - k);
    end
    r = (acc + 64'sd4194304) >>> 23;
    if (r > 64'sd8388607)  r = 64'sd8388607;
    if (r < -64'sd8388608) r = -64'sd8388608;
    return r;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts a sample on one instance; optional second tick while busy
  task automatic runSample(int inst, int n, int gap, bit extraTick);
    int g;
    int cur;
    longint exp;
    longint act;
    g = (TAPS_OF[inst] + LANES_OF[inst] - 1) / LANES_OF[inst];
    tick[inst] = 1'b1;
    @(negedge clk);
    if (extraTick) begin
      @(negedge clk);
      tick[inst] = 1'b0;
      check(ovr[inst] == 1'b1, "R7 overrun raised", longint'(ovr[inst]), 1);
      @(negedge clk);
      check(ovr[inst] == 1'b0, "R7 overrun one cycle", longint'(ovr[inst]), 0);
      cur = 3;
    end else begin
      tick[inst] = 1'b0;
      check(ovr[inst] == 1'b0, "R9 no overrun at minimum spacing", longint'(ovr[inst]), 0);
      cur = 1;
    end
    repeat (g + 1 - cur) @(negedge clk);
    check(valid[inst] == 1'b0, "R6 valid not early", longint'(valid[inst]), 0);
    @(negedge clk);
    check(valid[inst] == 1'b1, "R6 valid on time", longint'(valid[inst]), 1);
    exp = expectOut(inst, n);
    act = longint'($signed(outL[inst]));
    check(act == exp, "R3/R4 filtered value", act, exp);
    check(outR[inst] == outL[inst], "R5 channels equal",
          longint'($signed(outR[inst])), act);
    if (exp == 64'sd8388607 || exp == -64'sd8388608) begin
      if (act == exp) satHits++;
    end
    repeat (gap) @(negedge clk);
    if (gap > 1) begin
      check(longint'($signed(outL[inst])) == exp, "R6 output held",
            longint'($signed(outL[inst])), exp);
    end
  endtask

  initial begin
    for (int i = 0; i < NI; i++) tick[i] = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check(outL[i] == '0 && outR[i] == '0, "R1 reset outputs", longint'(outL[i]), 0);
      check(valid[i] == 1'b0 && ovr[i] == 1'b0, "R1 reset flags",
            longint'({valid[i], ovr[i]}), 0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // Main walk: 130 samples crosses the sawtooth wrap (R2)
    for (int n = 0; n < 130; n++) runSample(0, n, GAPS[n % 16], 1'b0);
    // R7: dropped tick must not consume a sample
    runSample(0, 130, 2, 1'b1);
    runSample(0, 131, 0, 1'b0);

    // R8 uneven lane split, R4 positive clamp
    satHits = 0;
    for (int n = 0; n < 70; n++) runSample(1, n, GAPS[n % 16], 1'b0);
    check(satHits > 0, "R4 positive saturation reached", satHits, 1);
    // R4 negative clamp, single lane group
    satHits = 0;
    for (int n = 0; n < 70; n++) runSample(2, n, GAPS[(n + 5) % 16], 1'b0);
    check(satHits > 0, "R4 negative saturation reached", satHits, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule